// File: doc/BRIEF.md
# Effective Vector Length Resolver

This block keeps one 4-bit length-control field for each privilege level above the lowest, and works out the vector length the core must use at its current privilege level. A field value n asks for n+1 quadword units, so a field can ask for 1 to 16 units. Software writes and reads the fields through a small register port. A read always returns the raw value that was stored.

The effective length at level k is the smallest field among levels k up to 3. Level 0 has no field and takes the limit that applies at level 1. The smallest field is then rounded down to a length the implementation supports. The supported lengths are given by a 16-bit parameter bitmap, in which bit i stands for i+1 units and bit 0 must be set.

The result is held in a register. A two-state controller recomputes it only after a write to a field that can affect the current level, or after a change of level. The controller rests in IDLE. A trigger (a relevant write or a level change) moves it to CALC. In CALC the new length is loaded and the valid pulse is raised on the following edge. CALC returns to IDLE when no new trigger arrives, and stays in CALC when one does.

Top module: `vlen_resolver`

## Requirements
- R1: After reset every stored field is 0, reads at every selector return 0, `eff_len` is 1 and `eff_valid` is 0.
- R2: A read returns, in bits [3:0], the low four bits of the last data written to that selector, with every higher bit zero. Writes to bits above [3:0] are dropped.
- R3: Selector 0 has no field. Writes to it are ignored, reads of it return 0, and writes to it start no recomputation.
- R4: At level k (1 to 3), the requested length is one plus the minimum of the fields of levels k through 3. At level 0 the minimum is taken over levels 1 through 3.
- R5: `eff_len`, in units, is the largest supported length that does not exceed the requested length. Bit i of the bitmap means i+1 units. The default bitmap supports 1, 2, 4, 8 and 16 units.
- R6: Rounding never changes a stored field. Reading a field back after it has been rounded gives the value that was written.
- R7: A write to selector s, with s nonzero and s at or above the current level, latches at clock edge E. `eff_valid` is then high in the cycle after edge E+1, and in that cycle `eff_len` holds the new value.
- R8: A change of `cur_lvl` seen at edge E gives the same timing as R7, with the length recomputed for the new level.
- R9: A write to a field below the current level gives no `eff_valid` pulse and leaves `eff_len` unchanged.
- R10: `eff_len` changes only in a cycle in which `eff_valid` is high.
- R11: Writes on two consecutive edges E and E+1 give `eff_valid` high for two consecutive cycles. The first of those cycles shows the length after the first write. The second shows the length after both writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_lvl | input | 2 | Current privilege level, 0 to 3 |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_sel | input | 2 | Selects the level field to read or write |
| reg_wdata | input | 32 | Write data; only bits [3:0] are kept |
| reg_rdata | output | 32 | Raw stored field of `reg_sel`, zero-extended |
| eff_len | output | 5 | Effective vector length in quadword units |
| eff_valid | output | 1 | One-cycle pulse when `eff_len` has just been recomputed |

## Verification
The assertions assume that `rst_n` is low from time zero until the first edges have passed. They also assume that `cur_lvl`, `reg_sel`, `reg_wr` and `reg_wdata` change only between clock edges. The readback property expects the selector to stay the same for the cycle after a write. The bench meets these assumptions by driving every input on the falling edge and holding reset low at the start. It reads a field only after the write to it has completed, and it samples results on falling edges.

// File: rtl/vlen_pkg.sv
package vlen_pkg;

    // Controller states: wait for a trigger, or load the recomputed length.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CALC = 1'b1
    } vlen_state_e;

endpackage

// File: rtl/vlen_fields.sv
// Per-level length fields. Level 0 has no storage and always reads zero.
module vlen_fields #(
    parameter int LEN_W   = 4,
    parameter int NUM_LVL = 4,
    parameter int DATA_W  = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [$clog2(NUM_LVL)-1:0]         wr_sel,
    input  logic [LEN_W-1:0]                   wr_len,
    input  logic [$clog2(NUM_LVL)-1:0]         rd_sel,
    output logic [DATA_W-1:0]                  rd_data,
    output logic [NUM_LVL-1:0][LEN_W-1:0]      fields
);

    localparam int LVL_W = $clog2(NUM_LVL);

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        if (g == 0) begin : g_none
            assign fields[g] = '0;
        end else begin : g_store
            logic [LEN_W-1:0] len_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    len_q <= '0;
                end else if (wr_en && wr_sel == LVL_W'(g)) begin
                    len_q <= wr_len;
                end
            end
            assign fields[g] = len_q;
        end
    end

    always_comb begin
        rd_data = '0;
        rd_data[LEN_W-1:0] = fields[rd_sel];
    end

endmodule

// File: rtl/vlen_min.sv
// Smallest field among the levels that constrain the given level.
module vlen_min #(
    parameter int LEN_W   = 4,
    parameter int NUM_LVL = 4
) (
    input  logic [$clog2(NUM_LVL)-1:0]         lvl,
    input  logic [NUM_LVL-1:0][LEN_W-1:0]      fields,
    output logic [LEN_W-1:0]                   min_len
);

    always_comb begin
        min_len = '1;
        for (int i = 1; i < NUM_LVL; i++) begin
            if (i >= int'(lvl) && fields[i] < min_len) begin
                min_len = fields[i];
            end
        end
    end

endmodule

// File: rtl/vlen_round.sv
// Round a requested length down to the largest supported one.
module vlen_round #(
    parameter int                       LEN_W         = 4,
    parameter logic [(1<<LEN_W)-1:0]    SUPPORTED_MAP = '1
) (
    input  logic [LEN_W-1:0]  req_len,
    output logic [LEN_W:0]    units
);

    localparam int MAX_UNITS = 1 << LEN_W;
    localparam int UNIT_W    = LEN_W + 1;

    always_comb begin
        units = UNIT_W'(1);
        for (int i = 0; i < MAX_UNITS; i++) begin
            if (SUPPORTED_MAP[i] && i <= int'(req_len)) begin
                units = UNIT_W'(i + 1);
            end
        end
    end

endmodule

// File: rtl/vlen_resolver.sv
// Effective vector length resolver: field storage, level tracking and
// a two-state controller that refreshes the cached length.
module vlen_resolver
    import vlen_pkg::*;
#(
    parameter int                       LEN_W         = 4,
    parameter int                       NUM_LVL       = 4,
    parameter int                       DATA_W        = 32,
    parameter logic [(1<<LEN_W)-1:0]    SUPPORTED_MAP = 16'h808B
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(NUM_LVL)-1:0]  cur_lvl,
    input  logic                        reg_wr,
    input  logic [$clog2(NUM_LVL)-1:0]  reg_sel,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    output logic [LEN_W:0]              eff_len,
    output logic                        eff_valid
);

    localparam int LVL_W  = $clog2(NUM_LVL);
    localparam int UNIT_W = LEN_W + 1;

    vlen_state_e                    state, state_nxt;
    logic [LVL_W-1:0]               lvl_q;
    logic [NUM_LVL-1:0][LEN_W-1:0]  fields;
    logic [LEN_W-1:0]               min_len;
    logic [UNIT_W-1:0]              units;
    logic                           lvl_chg, wr_hit, trig;
    logic                           unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:LEN_W];

    vlen_fields #(.LEN_W(LEN_W), .NUM_LVL(NUM_LVL), .DATA_W(DATA_W)) u_fields (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_sel  (reg_sel),
        .wr_len  (reg_wdata[LEN_W-1:0]),
        .rd_sel  (reg_sel),
        .rd_data (reg_rdata),
        .fields  (fields)
    );

    vlen_min #(.LEN_W(LEN_W), .NUM_LVL(NUM_LVL)) u_min (
        .lvl     (lvl_q),
        .fields  (fields),
        .min_len (min_len)
    );

    vlen_round #(.LEN_W(LEN_W), .SUPPORTED_MAP(SUPPORTED_MAP)) u_round (
        .req_len (min_len),
        .units   (units)
    );

    // Trigger: new level, or a write to a field that constrains this level.
    assign lvl_chg = (cur_lvl != lvl_q);
    assign wr_hit  = reg_wr && (reg_sel != '0) && (reg_sel >= lvl_q);
    assign trig    = lvl_chg || wr_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            lvl_q <= '0;
        end else begin
            state <= state_nxt;
            lvl_q <= cur_lvl;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (trig) state_nxt = ST_CALC;
            ST_CALC: state_nxt = trig ? ST_CALC : ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Outputs: the cached length is loaded only on leaving a CALC cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_len   <= UNIT_W'(1);
            eff_valid <= 1'b0;
        end else if (state == ST_CALC) begin
            eff_len   <= units;
            eff_valid <= 1'b1;
        end else begin
            eff_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/vlen_resolver_chk.sv
module vlen_resolver_chk #(
    parameter int                       LEN_W         = 4,
    parameter int                       NUM_LVL       = 4,
    parameter int                       DATA_W        = 32,
    parameter logic [(1<<LEN_W)-1:0]    SUPPORTED_MAP = 16'h808B
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(NUM_LVL)-1:0]  cur_lvl,
    input  logic                        reg_wr,
    input  logic [$clog2(NUM_LVL)-1:0]  reg_sel,
    input  logic [DATA_W-1:0]           reg_wdata,
    input  logic [DATA_W-1:0]           reg_rdata,
    input  logic [LEN_W:0]              eff_len,
    input  logic                        eff_valid
);

    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(reg_wr) && $past(reg_sel) != '0 && reg_sel == $past(reg_sel)
        |-> reg_rdata == DATA_W'($past(reg_wdata[LEN_W-1:0]))); // R2

    AST_LVL0_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel == '0 |-> reg_rdata == '0); // R3

    AST_LEN_SUPPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        eff_len != '0 && SUPPORTED_MAP[eff_len - 1'b1]); // R5

    AST_WRITE_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_sel != '0 && reg_sel >= cur_lvl |=> ##1 eff_valid); // R7

    AST_LEVEL_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        armed && cur_lvl != $past(cur_lvl) |=> ##1 eff_valid); // R8

    AST_CHANGE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        eff_len != $past(eff_len) |-> eff_valid); // R10

endmodule

bind vlen_resolver vlen_resolver_chk #(
    .LEN_W(LEN_W), .NUM_LVL(NUM_LVL), .DATA_W(DATA_W), .SUPPORTED_MAP(SUPPORTED_MAP)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_lvl   (cur_lvl),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .eff_len   (eff_len),
    .eff_valid (eff_valid)
);

// File: tb/vlen_resolver_test.sv
module vlen_resolver_test;

    localparam int          CLK_PERIOD = 10;
    localparam logic [15:0] MAP        = 16'h808B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cur_lvl = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [4:0]  eff_len;
    logic        eff_valid;

    int nchecks = 0;
    int nfail   = 0;
    int fld[4]  = '{0, 0, 0, 0};
    int mlvl    = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vlen_resolver uut (
        .clk(clk), .rst_n(rst_n), .cur_lvl(cur_lvl),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .eff_len(eff_len), .eff_valid(eff_valid)
    );

    function automatic int exp_units(int lvl);
        int lo = (lvl < 1) ? 1 : lvl;
        int m  = 15;
        int r  = 1;
        for (int i = lo; i <= 3; i++) if (fld[i] < m) m = fld[i];
        for (int i = 0; i < 16; i++) if (MAP[i] && i <= m) r = i + 1;
        return r;
    endfunction

    task automatic chk(string tag, int got, int exp);
        nchecks++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic wr(int sel, logic [31:0] d);
        reg_sel = sel[1:0]; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        if (sel != 0) fld[sel] = int'(d[3:0]);
    endtask

    task automatic rd_chk(string tag, int sel, int exp);
        reg_sel = sel[1:0];
        #1;
        chk(tag, int'(reg_rdata), exp);
    endtask

    task automatic expect_update(string tag);
        @(negedge clk);
        chk({tag, " valid"}, int'(eff_valid), 1);
        chk({tag, " len"}, int'(eff_len), exp_units(mlvl));
        @(negedge clk);
        chk({tag, " pulse end"}, int'(eff_valid), 0);
    endtask

    task automatic expect_quiet(string tag, int hold);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk({tag, " no valid"}, int'(eff_valid), 0);
            chk({tag, " len held"}, int'(eff_len), hold);
        end
    endtask

    task automatic set_lvl(int l);
        cur_lvl = l[1:0]; mlvl = l;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 len", int'(eff_len), 1);
        chk("R1 valid", int'(eff_valid), 0);
        for (int s = 0; s < 4; s++) rd_chk("R1 read", s, 0);
    endtask

    task automatic t_readback();
        wr(3, 32'hFFFF_FFF5); expect_update("R7 write l3");
        rd_chk("R2 upper bits dropped", 3, 5);
        wr(2, 32'h0000_001C); expect_update("R7 write l2");
        rd_chk("R2 low nibble", 2, 12);
    endtask

    task automatic t_lvl0();
        int hold = int'(eff_len);
        wr(0, 32'h0000_000F);
        expect_quiet("R3 sel0 write", hold);
        rd_chk("R3 sel0 read", 0, 0);
    endtask

    task automatic t_min();
        wr(1, 32'd15); expect_update("R4 min lvl0 a");
        wr(3, 32'd15); expect_update("R4 min lvl0 b");
        wr(2, 32'd15); expect_update("R4 all max");
        set_lvl(2);    expect_update("R8 to l2");
        wr(2, 32'd7);  expect_update("R4 l2 own");
        set_lvl(3);    expect_update("R8 to l3");
        set_lvl(1);    expect_update("R8 to l1");
    endtask

    task automatic t_round();
        int vals[6] = '{4, 14, 2, 1, 0, 15};
        set_lvl(3); expect_update("R8 to l3 again");
        foreach (vals[k]) begin
            wr(3, vals[k]);
            expect_update("R5 round");
            rd_chk("R6 stored raw", 3, vals[k]);
        end
    endtask

    task automatic t_ignore_lower();
        int hold = int'(eff_len);
        wr(1, 32'd0); expect_quiet("R9 l1 at l3", hold);
        wr(2, 32'd0); expect_quiet("R9 l2 at l3", hold);
        set_lvl(1);   expect_update("R9 later level change");
    endtask

    task automatic t_back2back();
        int mid;
        wr(2, 32'd15); expect_update("R11 prep");
        reg_sel = 2'd1; reg_wdata = 32'd15; reg_wr = 1'b1;
        @(negedge clk);
        fld[1] = 15;
        mid = exp_units(mlvl);
        reg_sel = 2'd3; reg_wdata = 32'd3;
        @(negedge clk);
        reg_wr = 1'b0;
        fld[3] = 3;
        chk("R11 first valid", int'(eff_valid), 1);
        chk("R11 first len", int'(eff_len), mid);
        @(negedge clk);
        chk("R11 second valid", int'(eff_valid), 1);
        chk("R11 final len", int'(eff_len), exp_units(mlvl));
        @(negedge clk);
        chk("R11 pulse end", int'(eff_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_lvl0();
        t_min();
        t_round();
        t_ignore_lower();
        t_back2back();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            nchecks++;
            nfail++;
            $display("FAIL watchdog got=%0d exp=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
            $finish;
        end
    end

endmodule